// File: doc/BRIEF.md
# Sidetone FIR Filter with Streamed Coefficient Loader

This block filters a stream of signed 16-bit sidetone samples with a 128-tap FIR filter. It then scales the filtered value by two independent signed gains and produces one output sample for each of two channels. Firmware reaches it over a plain 32-bit register bus that has a write strobe, a byte address and a combinational read path. Four locations matter: a system-configuration word, a packed two-channel gain word, a coefficient data port, and a control word that holds the path enable, the coefficient write enable and a done flag.

The taps are loaded through a handshake on a single port. Firmware raises the write enable, pushes 128 values through the coefficient port, polls the done flag, and then drops the write enable. The load is managed by a loader state machine with the states LD_IDLE, LD_FILL and LD_FULL:
- LD_IDLE goes to LD_FILL on a 0-to-1 edge of the write enable.
- LD_FILL goes to LD_FULL on the 128th data write.
- LD_FILL and LD_FULL both return to LD_IDLE when the write enable is cleared.

The filter is time-multiplexed and runs one multiply-accumulate per clock. Its state machine has the states FS_WAIT, FS_ACCUM and FS_EMIT:
- FS_WAIT goes to FS_ACCUM when a sample strobe is accepted.
- FS_ACCUM goes to FS_EMIT after the last tap.
- FS_ACCUM goes back to FS_WAIT if the path stops being active.
- FS_EMIT returns to FS_WAIT after one cycle, during which the gained result is registered.

Top module: `stfir_core`

## Requirements
- R1: Register offsets are 0x00 (identifier), 0x10 (system configuration), 0x24 (gain), 0x28 (coefficient port) and 0x2C (control). Offset 0x00 reads the constant 0x00010200. Any other offset, including 0x18, reads zero, and so does the coefficient port.
- R2: System-configuration bit 0 is an idle-request bit. It resets to 1, is readable and writable, and every other bit of that word reads zero.
- R3: Control bit 0 enables the path, bit 1 is the coefficient write enable, and bit 2 is a read-only done flag. All of them reset to 0. A 0-to-1 edge of bit 1 sets the tap pointer to 0 and clears the done flag. Clearing bit 1 leaves the done flag unchanged.
- R4: While a load is in progress, each write to 0x28 stores bits 15:0 as the next tap, starting at tap 0. The done flag reads 0 after 127 writes and 1 after the 128th.
- R5: A write to 0x28 while the write enable is 0, or after the 128th tap has been stored, leaves the taps unchanged.
- R6: Clearing and then setting the write enable part way through a load restarts the load at tap 0.
- R7: The gain word holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16, each as signed 16 bits, and reads back as written.
- R8: An accepted strobe shifts the sample into a 128-entry delay line, where entry 0 is the newest. The filter result is the sum of tap k times entry k, shifted right arithmetically by 15. The output-valid pulse lasts one cycle and appears on the 130th rising edge, counting the edge that captures the strobe as the first.
- R9: Each channel output is the filter result times its gain. The product has 2^14 added, is shifted right arithmetically by 15, and is saturated to the range -32768..32767.
- R10: While the enable bit is 0 or a load is in progress, both outputs read 0 from the second edge on, no valid pulse occurs, and sample strobes are ignored, so the delay line does not shift.
- R11: A strobe that arrives while a result is being computed is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse when a new result is registered |
| out_ch0 | output | 16 | Channel 0 result |
| out_ch1 | output | 16 | Channel 1 result |

## Verification
The filter is driven with a table of samples that mix sign and magnitude, loaded against small mixed-sign taps. Each vector carries its own pair of gains: unity, one half, minus one half, minus one and tiny values. Together these separate mistakes in the tap or sample ordering, the floor shift, the round-half-up step and the channel packing. A second load of full-scale taps drives the results past both saturation limits. Strobes that are sent while the path is disabled, during a load, or while a result is still being computed must leave later results exactly as if they had never been sent. Stray coefficient writes, both before the load is enabled and after it is complete, must not alter any result either.

// File: rtl/stfir_pkg.sv
package stfir_pkg;
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_FULL = 2'd2
    } ld_state_e;

    typedef enum logic [1:0] {
        FS_WAIT  = 2'd0,
        FS_ACCUM = 2'd1,
        FS_EMIT  = 2'd2
    } fir_state_e;

    localparam logic [7:0]  OFS_IDENT  = 8'h00;
    localparam logic [7:0]  OFS_SYSCFG = 8'h10;
    localparam logic [7:0]  OFS_GAIN   = 8'h24;
    localparam logic [7:0]  OFS_COEF   = 8'h28;
    localparam logic [7:0]  OFS_CTRL   = 8'h2C;
    localparam logic [31:0] IDENT_WORD = 32'h0001_0200;
endpackage

// File: rtl/stfir_loader.sv
module stfir_loader
    import stfir_pkg::*;
#(
    parameter int NTAPS = 128,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctrl_wr,
    input  logic                       wren_in,
    input  logic                       coef_wr,
    input  logic [DW-1:0]              coef_in,
    output logic                       wren,
    output logic                       done,
    output logic                       loading,
    output logic                       mem_we,
    output logic [$clog2(NTAPS)-1:0]   mem_addr,
    output logic [DW-1:0]              mem_data
);
    localparam int TW = $clog2(NTAPS);
    localparam logic [TW-1:0] LAST = TW'(NTAPS - 1);

    ld_state_e state_q, state_d;
    logic [TW-1:0] ptr_q;
    logic          done_q;
    logic          start, stop, store;

    assign start = ctrl_wr && wren_in && (state_q == LD_IDLE);
    assign stop  = ctrl_wr && !wren_in;
    assign store = coef_wr && (state_q == LD_FILL) && !stop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (start) state_d = LD_FILL;
            LD_FILL: begin
                if (stop) state_d = LD_IDLE;
                else if (coef_wr && ptr_q == LAST) state_d = LD_FULL;
            end
            LD_FULL: if (stop) state_d = LD_IDLE;
            default: state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                ptr_q  <= '0;
                done_q <= 1'b0;
            end else if (store) begin
                ptr_q <= ptr_q + 1'b1;
                if (ptr_q == LAST) done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        wren     = (state_q != LD_IDLE);
        loading  = (state_q == LD_FILL);
        done     = done_q;
        mem_we   = store;
        mem_addr = ptr_q;
        mem_data = coef_in;
    end

    // R3: a fresh load starts at tap 0 with the flag clear
    p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wren) |-> (ptr_q == '0) && !done_q);
    // R4: the flag only rises on the final tap write
    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(state_q == LD_FILL && ptr_q == LAST && coef_wr));
    // R4: a full store always reports done
    p_full_has_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_FULL) |-> done_q);
endmodule

// File: rtl/stfir_coef_store.sv
module stfir_coef_store #(
    parameter int NTAPS = 128,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NTAPS)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(NTAPS)-1:0] raddr,
    output logic signed [DW-1:0]     rdata
);
    logic signed [DW-1:0] mem_q [NTAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NTAPS; k++) mem_q[k] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/stfir_mac.sv
module stfir_mac
    import stfir_pkg::*;
#(
    parameter int NTAPS = 128,
    parameter int DW    = 16,
    parameter int ACCW  = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active,
    input  logic                          smp_valid,
    input  logic signed [DW-1:0]          smp_data,
    output logic [$clog2(NTAPS)-1:0]      tap_idx,
    input  logic signed [DW-1:0]          tap_val,
    output logic                          res_valid,
    output logic signed [ACCW-DW:0]       res_filt
);
    localparam int TW = $clog2(NTAPS);
    localparam int PW = 2 * DW;
    localparam logic [TW-1:0] LAST = TW'(NTAPS - 1);

    fir_state_e state_q, state_d;
    logic [TW-1:0]         idx_q;
    logic signed [ACCW-1:0] acc_q;
    logic signed [DW-1:0]  dline_q [NTAPS];
    logic signed [PW-1:0]  prod;
    logic                  accept;

    assign accept = (state_q == FS_WAIT) && active && smp_valid;
    assign prod   = tap_val * dline_q[idx_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_WAIT:  if (accept) state_d = FS_ACCUM;
            FS_ACCUM: begin
                if (!active) state_d = FS_WAIT;
                else if (idx_q == LAST) state_d = FS_EMIT;
            end
            FS_EMIT:  state_d = FS_WAIT;
            default:  state_d = FS_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_WAIT;
            idx_q   <= '0;
            acc_q   <= '0;
            for (int k = 0; k < NTAPS; k++) dline_q[k] <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dline_q[0] <= smp_data;
                for (int k = 1; k < NTAPS; k++) dline_q[k] <= dline_q[k-1];
                idx_q <= '0;
                acc_q <= '0;
            end else if (state_q == FS_ACCUM) begin
                acc_q <= acc_q + ACCW'(prod);
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    logic unused_low;
    assign unused_low = ^acc_q[DW-2:0];

    always_comb begin
        tap_idx   = idx_q;
        res_valid = (state_q == FS_EMIT);
        res_filt  = acc_q[ACCW-1:DW-1];
    end

    // R8: the emit state follows only the last accumulation step
    p_emit_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_EMIT) |-> $past(state_q == FS_ACCUM && idx_q == LAST));
    // R11: a strobe during accumulation does not disturb the delay line
    p_busy_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_ACCUM && smp_valid) |=> $stable(dline_q[0]));
endmodule

// File: rtl/stfir_gain.sv
module stfir_gain #(
    parameter int DW = 16,
    parameter int FW = 25
) (
    input  logic signed [FW-1:0] filt,
    input  logic signed [DW-1:0] gain,
    output logic signed [DW-1:0] result
);
    localparam int XW = FW + DW;
    localparam logic signed [XW-1:0] RND  = XW'(1) <<< (DW - 2);
    localparam logic signed [XW-1:0] MAXV = XW'((1 << (DW - 1)) - 1);
    localparam logic signed [XW-1:0] MINV = -(XW'(1) <<< (DW - 1));

    logic signed [XW-1:0] prod, shifted;

    always_comb begin
        prod    = filt * gain;
        shifted = (prod + RND) >>> (DW - 1);
        if (shifted > MAXV)      result = MAXV[DW-1:0];
        else if (shifted < MINV) result = MINV[DW-1:0];
        else                     result = shifted[DW-1:0];
    end
endmodule

// File: rtl/stfir_core.sv
module stfir_core
    import stfir_pkg::*;
#(
    parameter int NTAPS = 128,
    parameter int DW    = 16,
    parameter int ACCW  = 40,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          out_valid,
    output logic [DW-1:0] out_ch0,
    output logic [DW-1:0] out_ch1
);
    localparam int TW = $clog2(NTAPS);
    localparam int FW = ACCW - DW + 1;
    localparam int NCH = 2;

    logic            idle_req_q, enable_q;
    logic [31:0]     gain_q;
    logic            wr_sys, wr_gain, wr_coef, wr_ctrl;
    logic            wren, done, loading, active;
    logic            mem_we;
    logic [TW-1:0]   mem_addr, rd_idx;
    logic [DW-1:0]   mem_data;
    logic signed [DW-1:0] tap_val;
    logic            res_valid;
    logic signed [FW-1:0] res_filt;
    logic signed [DW-1:0] ch_res [NCH];
    logic [DW-1:0]   ch_q [NCH];
    logic            valid_q;

    assign wr_sys  = bus_wr && (bus_addr == AW'(OFS_SYSCFG));
    assign wr_gain = bus_wr && (bus_addr == AW'(OFS_GAIN));
    assign wr_coef = bus_wr && (bus_addr == AW'(OFS_COEF));
    assign wr_ctrl = bus_wr && (bus_addr == AW'(OFS_CTRL));
    assign active  = enable_q && !loading;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_req_q <= 1'b1;
            enable_q   <= 1'b0;
            gain_q     <= '0;
        end else begin
            if (wr_sys)  idle_req_q <= bus_wdata[0];
            if (wr_ctrl) enable_q   <= bus_wdata[0];
            if (wr_gain) gain_q     <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            AW'(OFS_IDENT):  bus_rdata = IDENT_WORD;
            AW'(OFS_SYSCFG): bus_rdata = {31'd0, idle_req_q};
            AW'(OFS_GAIN):   bus_rdata = gain_q;
            AW'(OFS_CTRL):   bus_rdata = {29'd0, done, wren, enable_q};
            default:         bus_rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[31:DW];

    stfir_loader #(.NTAPS(NTAPS), .DW(DW)) u_loader (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_ctrl), .wren_in(bus_wdata[1]),
        .coef_wr(wr_coef), .coef_in(bus_wdata[DW-1:0]),
        .wren(wren), .done(done), .loading(loading),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    stfir_coef_store #(.NTAPS(NTAPS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
        .raddr(rd_idx), .rdata(tap_val)
    );

    stfir_mac #(.NTAPS(NTAPS), .DW(DW), .ACCW(ACCW)) u_mac (
        .clk(clk), .rst_n(rst_n), .active(active),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .tap_idx(rd_idx), .tap_val(tap_val),
        .res_valid(res_valid), .res_filt(res_filt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        stfir_gain #(.DW(DW), .FW(FW)) u_gain (
            .filt(res_filt),
            .gain(gain_q[c*DW +: DW]),
            .result(ch_res[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            for (int c = 0; c < NCH; c++) ch_q[c] <= '0;
        end else if (!active) begin
            valid_q <= 1'b0;
            for (int c = 0; c < NCH; c++) ch_q[c] <= '0;
        end else begin
            valid_q <= res_valid;
            if (res_valid) begin
                for (int c = 0; c < NCH; c++) ch_q[c] <= ch_res[c];
            end
        end
    end

    assign out_valid = valid_q;
    assign out_ch0   = ch_q[0];
    assign out_ch1   = ch_q[1];

    // R10: an inactive path drives silence on the next cycle
    p_silent_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (out_ch0 == '0) && (out_ch1 == '0) && !out_valid);
    // R8: the valid strobe is a single-cycle pulse
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: tb/stfir_core_bench.sv
`timescale 1ns/1ps
module stfir_core_bench;
    localparam int NT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        out_valid;
    logic [15:0] out_ch0, out_ch1;

    int n_chk = 0;
    int n_err = 0;
    longint bc [NT];
    longint bd [NT];

    always #2 clk = ~clk;

    stfir_core u_stfir_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .out_valid(out_valid), .out_ch0(out_ch0),
        .out_ch1(out_ch1)
    );

    // {sample, gain1, gain0}
    localparam logic [47:0] VEC [8] = '{
        {16'sd20000,  16'h7FFF, 16'h4000},
        {-16'sd15000, 16'hC000, 16'h7FFF},
        {16'sd32767,  16'h8000, 16'h0001},
        {-16'sd32768, 16'h2000, 16'hE000},
        {16'sd1234,   16'h7FFF, 16'h8000},
        {16'sd0,      16'h4000, 16'h4000},
        {-16'sd7,     16'h0003, 16'hFFFD},
        {16'sd25000,  16'h6000, 16'hA000}
    };

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic longint sat16(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint expect_ch(longint g);
        longint s = 0;
        longint f;
        for (int k = 0; k < NT; k++) s += bc[k] * bd[k];
        f = s >>> 15;
        return sat16(((f * g) + 16384) >>> 15);
    endfunction

    function automatic void model_accept(longint s);
        for (int k = NT - 1; k > 0; k--) bd[k] = bd[k-1];
        bd[0] = s;
    endfunction

    task automatic send_sample(input logic [15:0] s, output int lat);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s;
        @(negedge clk);
        smp_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic send_ignored(input logic [15:0] s, input string tag);
        int seen = 0;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = s;
        @(negedge clk);
        smp_valid = 1'b0;
        for (int i = 0; i < NT + 10; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic expect_out(longint g0, longint g1, string tag);
        chk({tag, " ch0"}, longint'($signed(out_ch0)), expect_ch(g0));
        chk({tag, " ch1"}, longint'($signed(out_ch1)), expect_ch(g1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        for (int k = 0; k < NT; k++) begin
            bd[k] = 0;
            bc[k] = ((k * 73) % 64) - 32;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and register map
        bread(8'h00, rd); chk("R1 identifier", rd, 32'h0001_0200);
        bread(8'h18, rd); chk("R1 unmapped 0x18", rd, 0);
        bread(8'h28, rd); chk("R1 coef port reads 0", rd, 0);
        bread(8'h10, rd); chk("R2 sysconfig reset", rd, 1);
        bwrite(8'h10, 32'hFFFF_FFFE);
        bread(8'h10, rd); chk("R2 sysconfig cleared", rd, 0);
        bwrite(8'h10, 32'h0000_0001);
        bread(8'h10, rd); chk("R2 sysconfig set", rd, 1);
        bread(8'h2C, rd); chk("R3 ctrl reset", rd, 0);
        chk("R10 reset outputs", {out_valid, out_ch0, out_ch1}, 0);

        // First load
        bwrite(8'h2C, 32'h2);
        for (int k = 0; k < NT - 1; k++) bwrite(8'h28, 32'(bc[k][15:0]));
        bread(8'h2C, rd); chk("R4 done low after 127", rd[2], 0);
        bwrite(8'h28, 32'(bc[NT-1][15:0]));
        bread(8'h2C, rd); chk("R4 ctrl after 128", rd, 32'h6);
        bwrite(8'h28, 32'h0000_7FFF);          // R5: past the end
        bwrite(8'h2C, 32'h0);
        bread(8'h2C, rd); chk("R3 done kept after wren clear", rd, 32'h4);
        bwrite(8'h28, 32'h0000_5555);          // R5: wren low
        bwrite(8'h2C, 32'h1);

        bwrite(8'h24, 32'hC000_7FFF);
        bread(8'h24, rd); chk("R7 gain readback", rd, 32'hC000_7FFF);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            bwrite(8'h24, {VEC[v][31:16], VEC[v][15:0]});
            send_sample(VEC[v][47:32], lat);
            model_accept(longint'($signed(VEC[v][47:32])));
            if (v == 0) chk("R8 latency", lat, NT + 1);
            expect_out(longint'($signed(VEC[v][15:0])),
                       longint'($signed(VEC[v][31:16])), "R8 R9 R5 vector");
            @(negedge clk);
            chk("R8 pulse width", out_valid, 0);
        end

        // R11: strobe during computation is dropped
        bwrite(8'h24, 32'h7FFF_4000);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'sd9000;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (5) @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'sd31000;
        @(negedge clk);
        smp_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        model_accept(9000);
        expect_out(16'sh4000, 16'sh7FFF, "R11 first result");
        send_sample(16'sd100, lat);
        model_accept(100);
        expect_out(16'sh4000, 16'sh7FFF, "R11 busy strobe dropped");

        // R10: disabled path
        bwrite(8'h2C, 32'h0);
        @(negedge clk);
        chk("R10 disabled outputs zero", {out_ch0, out_ch1}, 0);
        send_ignored(16'sd30000, "R10 no pulse when disabled");
        bwrite(8'h2C, 32'h1);
        send_sample(-16'sd4000, lat);
        model_accept(-4000);
        expect_out(16'sh4000, 16'sh7FFF, "R10 ignored strobe not shifted");

        // R6: restart mid-load
        bwrite(8'h2C, 32'h3);
        @(negedge clk);
        chk("R10 loading outputs zero", {out_ch0, out_ch1}, 0);
        bread(8'h2C, rd); chk("R3 done cleared on edge", rd[2], 0);
        send_ignored(16'sd12345, "R10 no pulse while loading");
        for (int k = 0; k < 10; k++) bwrite(8'h28, 32'h0000_1111);
        bwrite(8'h2C, 32'h1);
        bwrite(8'h2C, 32'h3);
        for (int k = 0; k < NT; k++) begin
            bc[k] = (k < 4) ? 32767 : -1;
            bwrite(8'h28, 32'(bc[k][15:0]));
        end
        bread(8'h2C, rd); chk("R6 restart done", rd, 32'h7);
        bwrite(8'h2C, 32'h1);
        bwrite(8'h24, 32'h8000_7FFF);
        for (int i = 0; i < 3; i++) begin
            send_sample(16'sd30000, lat);
            model_accept(30000);
            expect_out(16'sh7FFF, -32768, "R6 R9 saturation");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule